// File: doc/BRIEF.md
# Zero-Voltage-Switching On/Off Timing Controller

This block sets the switching rhythm of a single-switch quasi-resonant power stage. A saturating 12-bit up/down counter replaces the usual timing capacitor. During the off phase the counter climbs by a programmable step each clock, and the rate of that climb fixes the longest allowed off time. During the on phase the counter descends by a second programmable step, and that rate fixes the on time. The counter moves between a low and a high threshold that stand in a 1:3 ratio. The gate request is held low while the counter climbs and may be high while it descends.

An off phase can end in one of two ways. The usual way is for the counter to reach the high threshold. It also ends early when the synchronised zero-voltage flag reports that the switch voltage has rung down. This early exit is only accepted once the counter is above a middle threshold, so the switch is not turned straight back on after it turns off. It is also refused while a current-limit event is latched. When the current-limit flag asserts during the on phase, three things happen at once: the gate is pulled low, the counter collapses to the low threshold, and the current-limit latch sets. Collapsing the counter shortens the on time without making the next off time longer. A drive-enable input holds the whole controller idle when it is low.

Top module: `zvs_timing_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after it, `gateDrive`, `onPhase` and `clLatched` are 0 and the counter rests at the low threshold (default 1000).
- R2: In the off phase (`onPhase`=0) the counter rises by `upStep` each clock, clamped at the high threshold (default 3000), and `gateDrive` stays 0.
- R3: In the off phase, on the clock where the counter already equals the high threshold, the on phase begins: `onPhase` and `gateDrive` read 1 after that edge.
- R4: In the on phase the counter falls by `downStep` each clock, clamped at the low threshold. On the clock after the counter reaches the low threshold, `onPhase` and `gateDrive` return to 0 and a new off phase starts from the low threshold.
- R5: A synchronised zero-voltage flag ends the off phase early, starting the on phase at the next edge. This only happens when the counter is strictly above the middle threshold (default 1500) and `clLatched` is 0. At or below the middle threshold the flag has no effect.
- R6: When the synchronised current-limit flag is 1 during the on phase, the next edge sets `clLatched` to 1, forces `gateDrive` and `onPhase` to 0, and reloads the counter with the low threshold.
- R7: `clLatched` stays 1 for the whole off phase that follows, and zero-voltage flags are ignored during that time. The latch clears on the edge where the counter at the high threshold starts the next on phase.
- R8: While `driveEn` is 0, each edge forces `gateDrive`, `onPhase` and `clLatched` to 0 and reloads the counter with the low threshold. After `driveEn` returns to 1, operation resumes with an off phase.
- R9: `zvdRaw` and `clRaw` pass through a two-flop synchroniser. A raw level first affects the state two edges after it is sampled, and a one-clock raw pulse is still acted on.
- R10: The counter either rises or falls on any clock, never both. With the largest steps (255), the rise and the fall land exactly on the high and low thresholds and never go past them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| driveEn | input | 1 | Global enable; when 0 the controller idles with the gate off |
| zvdRaw | input | 1 | Zero-voltage comparator flag, asynchronous |
| clRaw | input | 1 | Current-limit comparator flag, asynchronous |
| upStep | input | 8 | Counter increment per clock during the off phase |
| downStep | input | 8 | Counter decrement per clock during the on phase |
| gateDrive | output | 1 | Registered gate drive request |
| onPhase | output | 1 | Phase status: 1 while the counter is falling |
| clLatched | output | 1 | Current-limit latch state |

## Verification
The bench targets four areas.

The first is the masking window for the zero-voltage flag. The flag is held high from the very start of an off phase. A design that compared against the wrong threshold, or ignored the mask entirely, would turn the switch on again just after turning it off.

The second is a current-limit pulse in the middle of the on phase, followed by an off phase with the zero-voltage flag held high. A design that waited for the counter to run down, cleared the latch too early, or let the flag through while the latch was set would show a longer on pulse or a shortened off phase.

The third is a single-clock zero-voltage pulse together with the two-edge synchroniser latency, which catches an extra or missing stage. The last is the largest step sizes, where a counter without saturation would wrap around or overshoot a threshold.

// File: rtl/zvs_pkg.sv
package zvs_pkg;

  // Strobes from the phase control to the ramp datapath
  typedef struct packed {
    logic loadLow;
    logic stepUp;
    logic stepDown;
  } rampCmd_t;

  // Threshold comparisons from the datapath back to the control
  typedef struct packed {
    logic atHigh;
    logic atLow;
    logic aboveMid;
  } rampStat_t;

endpackage

// File: rtl/zvs_sync.sv
module zvs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/zvs_ramp_dp.sv
module zvs_ramp_dp
  import zvs_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned STEP_W  = 8,
  parameter int unsigned LOW_TH  = 1000,
  parameter int unsigned MID_TH  = 1500,
  parameter int unsigned HIGH_TH = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCmd_t          cmd,
  input  logic [STEP_W-1:0] upStep,
  input  logic [STEP_W-1:0] downStep,
  output rampStat_t         stat
);

  localparam int unsigned EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW_TH);
  localparam logic [CNT_W-1:0] MID_V  = CNT_W'(MID_TH);
  localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_TH);
  localparam logic [EXT_W-1:0] LOW_X  = EXT_W'(LOW_TH);
  localparam logic [EXT_W-1:0] HIGH_X = EXT_W'(HIGH_TH);

  logic [CNT_W-1:0] ramp;
  logic [CNT_W-1:0] rampNext;
  logic [EXT_W-1:0] rampX;
  logic [EXT_W-1:0] upX;
  logic [EXT_W-1:0] downX;
  logic [EXT_W-1:0] sumX;
  logic             floorHit;

  assign rampX    = {1'b0, ramp};
  assign upX      = EXT_W'(upStep);
  assign downX    = EXT_W'(downStep);
  assign sumX     = rampX + upX;
  assign floorHit = rampX < (LOW_X + downX);

  always_comb begin
    rampNext = ramp;
    if (cmd.loadLow) begin
      rampNext = LOW_V;
    end else if (cmd.stepUp) begin
      rampNext = (sumX >= HIGH_X) ? HIGH_V : sumX[CNT_W-1:0];
    end else if (cmd.stepDown) begin
      rampNext = floorHit ? LOW_V : (ramp - CNT_W'(downStep));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ramp <= LOW_V;
    else       ramp <= rampNext;
  end

  assign stat.atHigh   = ramp >= HIGH_V;
  assign stat.atLow    = ramp <= LOW_V;
  assign stat.aboveMid = ramp > MID_V;

  // R10
  excl_motion_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadLow, cmd.stepUp, cmd.stepDown}));

  // R2
  rise_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepUp |=> (ramp >= $past(ramp)) && (ramp <= HIGH_V));

  // R4
  fall_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepDown |=> (ramp <= $past(ramp)) && (ramp >= LOW_V));

endmodule

// File: rtl/zvs_phase_ctrl.sv
module zvs_phase_ctrl
  import zvs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      driveEn,
  input  logic      zvdSync,
  input  logic      clSync,
  input  rampStat_t stat,
  output rampCmd_t  cmd,
  output logic      gateDrive,
  output logic      onPhase,
  output logic      clLatched
);

  logic drvQ, drvN;
  logic clQ, clN;
  logic gateQ, gateN;
  logic zvdAccept;

  assign zvdAccept = zvdSync && stat.aboveMid && !clQ;

  always_comb begin
    cmd  = '0;
    drvN = drvQ;
    clN  = clQ;
    if (!driveEn) begin
      cmd.loadLow = 1'b1;
      drvN        = 1'b0;
      clN         = 1'b0;
    end else if (!drvQ) begin
      clN = clQ | clSync;
      if (stat.atHigh || zvdAccept) begin
        drvN = 1'b1;
        clN  = 1'b0;
      end else begin
        cmd.stepUp = 1'b1;
      end
    end else begin
      if (clSync) begin
        clN         = 1'b1;
        drvN        = 1'b0;
        cmd.loadLow = 1'b1;
      end else if (stat.atLow) begin
        drvN = 1'b0;
      end else begin
        cmd.stepDown = 1'b1;
      end
    end
    gateN = drvN && !clN && driveEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvQ  <= 1'b0;
      clQ   <= 1'b0;
      gateQ <= 1'b0;
    end else begin
      drvQ  <= drvN;
      clQ   <= clN;
      gateQ <= gateN;
    end
  end

  assign gateDrive = gateQ;
  assign onPhase   = drvQ;
  assign clLatched = clQ;

  // R3
  high_sets_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveEn && !drvQ && stat.atHigh |=> drvQ);

  // R5
  zvd_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveEn && !drvQ && !stat.atHigh && !stat.aboveMid |=> !drvQ);

  // R6
  cl_collapse_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveEn && drvQ && clSync |=> !gateQ && !drvQ && clQ);

  // R7
  cl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveEn && !drvQ && clQ && !stat.atHigh |=> !drvQ && clQ);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |=> !gateQ && !drvQ && !clQ);

endmodule

// File: rtl/zvs_timing_ctrl.sv
module zvs_timing_ctrl
  import zvs_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned STEP_W  = 8,
  parameter int unsigned LOW_TH  = 1000,
  parameter int unsigned MID_TH  = 1500,
  parameter int unsigned HIGH_TH = 3000,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              driveEn,
  input  logic              zvdRaw,
  input  logic              clRaw,
  input  logic [STEP_W-1:0] upStep,
  input  logic [STEP_W-1:0] downStep,
  output logic              gateDrive,
  output logic              onPhase,
  output logic              clLatched
);

  logic [1:0] flagSync;
  rampCmd_t   cmd;
  rampStat_t  stat;

  zvs_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({zvdRaw, clRaw}),
    .syncOut (flagSync)
  );

  zvs_ramp_dp #(
    .CNT_W(CNT_W), .STEP_W(STEP_W),
    .LOW_TH(LOW_TH), .MID_TH(MID_TH), .HIGH_TH(HIGH_TH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .upStep   (upStep),
    .downStep (downStep),
    .stat     (stat)
  );

  zvs_phase_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .driveEn   (driveEn),
    .zvdSync   (flagSync[1]),
    .clSync    (flagSync[0]),
    .stat      (stat),
    .cmd       (cmd),
    .gateDrive (gateDrive),
    .onPhase   (onPhase),
    .clLatched (clLatched)
  );

  // R2
  off_gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !onPhase |-> !gateDrive);

endmodule

// File: tb/zvs_timing_ctrl_bench.sv
module zvs_timing_ctrl_bench;

  localparam int LOW  = 1000;
  localparam int MID  = 1500;
  localparam int HIGH = 3000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       driveEn;
  logic       zvdRaw;
  logic       clRaw;
  logic [7:0] upStep;
  logic [7:0] downStep;
  logic       gateDrive;
  logic       onPhase;
  logic       clLatched;

  int    compared   = 0;
  int    mismatched = 0;
  bit    done       = 0;
  string curReq     = "R1";

  always #5 clk = ~clk;

  zvs_timing_ctrl u_zvs_timing_ctrl (
    .clk(clk), .rstN(rstN), .driveEn(driveEn), .zvdRaw(zvdRaw), .clRaw(clRaw),
    .upStep(upStep), .downStep(downStep),
    .gateDrive(gateDrive), .onPhase(onPhase), .clLatched(clLatched)
  );

  // Behavioural reference: flag delay lines and the phase/ramp rules
  int mRamp;
  bit mDrv, mCl, mGate;
  bit zPipe[$];
  bit cPipe[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mRamp = LOW; mDrv = 0; mCl = 0; mGate = 0;
      zPipe = '{0, 0};
      cPipe = '{0, 0};
    end else begin
      bit zs, cs, nD, nC;
      int nR;
      zs = zPipe[0];
      cs = cPipe[0];
      nR = mRamp; nD = mDrv; nC = mCl;
      if (!driveEn) begin
        nR = LOW; nD = 0; nC = 0;
      end else if (!mDrv) begin
        nC = mCl || cs;
        if (mRamp >= HIGH || (zs && mRamp > MID && !mCl)) begin
          nD = 1; nC = 0;
        end else begin
          nR = mRamp + int'(upStep);
          if (nR > HIGH) nR = HIGH;
        end
      end else if (cs) begin
        nC = 1; nD = 0; nR = LOW;
      end else if (mRamp <= LOW) begin
        nD = 0;
      end else begin
        nR = mRamp - int'(downStep);
        if (nR < LOW) nR = LOW;
      end
      mGate = nD && !nC && driveEn;
      mRamp = nR; mDrv = nD; mCl = nC;
      void'(zPipe.pop_front());
      void'(cPipe.pop_front());
      zPipe.push_back(zvdRaw);
      cPipe.push_back(clRaw);
    end
  end

  task automatic check(string what, bit act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("gateDrive", gateDrive, mGate);
      check("onPhase", onPhase, mDrv);
      check("clLatched", clLatched, mCl);
    end
  end

  task automatic waitOn();
    while (!onPhase) @(negedge clk);
  endtask

  task automatic waitOff();
    while (onPhase) @(negedge clk);
  endtask

  initial begin
    rstN = 0; driveEn = 1; zvdRaw = 0; clRaw = 0;
    upStep = 8'd100; downStep = 8'd50;
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R2 rising off phase, R3 top of ramp, R4 falling on phase
    curReq = "R2"; repeat (20) @(negedge clk);
    curReq = "R3"; repeat (4) @(negedge clk);
    curReq = "R4"; repeat (60) @(negedge clk);
    // R5: flag held from the start of the off phase, masked below mid
    upStep = 8'd20;
    waitOn(); waitOff();
    curReq = "R5"; zvdRaw = 1;
    repeat (45) @(negedge clk);
    zvdRaw = 0;
    // R9: single-clock flag pulse, two-edge latency
    waitOn(); waitOff();
    curReq = "R9";
    repeat (30) @(negedge clk);
    zvdRaw = 1; @(negedge clk); zvdRaw = 0;
    repeat (10) @(negedge clk);
    // R6: current limit in the middle of a long on phase
    downStep = 8'd10;
    waitOn();
    repeat (5) @(negedge clk);
    curReq = "R6"; clRaw = 1;
    repeat (2) @(negedge clk);
    clRaw = 0;
    repeat (4) @(negedge clk);
    // R7: latch holds through the off phase, flag ignored
    curReq = "R7"; zvdRaw = 1;
    repeat (120) @(negedge clk);
    zvdRaw = 0;
    // R8: enable dropped during an on phase
    waitOn();
    repeat (3) @(negedge clk);
    curReq = "R8"; driveEn = 0;
    repeat (5) @(negedge clk);
    driveEn = 1;
    repeat (30) @(negedge clk);
    // R10: largest steps clamp exactly at both thresholds
    curReq = "R10"; upStep = 8'd255; downStep = 8'd255;
    repeat (80) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL %s watchdog actual=hung expected=finished", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule